// File: doc/BRIEF.md
# SHA-1 Stream Hasher

The block computes a 160-bit SHA-1 digest over a message that arrives as a stream of 32-bit words. The most significant word of each 512-bit block comes first. The producer offers a word with `in_valid`, and the word is taken on a rising edge where `in_ready` is also high. A word offered with `in_iv` set is taken as part of a custom starting chaining value instead of as message data. Five such words, given before the first message word, set H0 through H4 in order. This lets a precomputed HMAC inner or outer state be resumed.

The producer marks the final message word with `in_last`. `in_nbits` then gives how many leading bits of that word belong to the message. The block pads the message on its own: it masks off the unused bits, appends the single one bit and the zero fill, and writes the 64-bit bit length. It adds a further block when the length field does not fit. Each block is compressed in 81 cycles: one load cycle followed by 80 step cycles. `in_ready` stays low for that whole time.

The digest is returned on `out_data` as five registered words. `out_valid` is high for five consecutive cycles and `out_addr` counts 0 to 4, where word 0 is H0 (most significant). The output has no back-pressure, so the consumer must take each word in the cycle it is shown. After the fifth word the block returns to its reset chaining state and a zero length count, ready for the next message.

Top module: `sha1_stream_hasher`

## Requirements
- R1: `rst` is asynchronous and active high. After it, `in_ready` is 1, `out_valid` is 0, and the chaining state is 67452301, EFCDAB89, 98BADCFE, 10325476, C3D2E1F0.
- R2: For a message given as 32-bit words, most significant word first, the five digest words equal the standard SHA-1 digest of that message.
- R3: On the `in_last` word, `in_nbits` = 0 means all 32 bits are message bits. A value n from 1 to 31 means only bits 31 down to 32-n are message bits, and the rest are replaced by padding. The padding is one 1 bit, then zeros, then the 64-bit total bit length in the last two words of a block. An extra block is added when fewer than 65 bits remain after the message.
- R4: Words taken with `in_iv` = 1 load H0, H1, H2, H3, H4 in that order. The digest is then computed from that chaining value. A message without IV words starts from the R1 constants.
- R5: When `in_valid` is 0, the values on `in_iv`, `in_last`, `in_data` and `in_nbits` have no effect. `in_nbits` has no effect on a word taken with `in_last` = 0.
- R6: Once the 16th word of a block is taken (message or padding), `in_ready` is low for exactly 81 cycles, and no word is taken while compression runs.
- R7: A digest appears as five consecutive cycles with `out_valid` = 1 and `out_addr` = 0, 1, 2, 3, 4. `out_addr` 0 carries H0, and `out_valid` falls after address 4.
- R8: After a digest is delivered, the next message starts from the R1 constants with its length count at zero. Back-to-back messages each give their own correct digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| in_valid | input | 1 | Producer offers a word |
| in_iv | input | 1 | Offered word is a chaining-value word, not message data |
| in_data | input | 32 | Offered word |
| in_last | input | 1 | Offered word is the final message word |
| in_nbits | input | 5 | Message bits in the final word, 0 meaning 32 |
| in_ready | output | 1 | Block takes the offered word on this edge |
| out_valid | output | 1 | A digest word is on `out_data` |
| out_addr | output | 3 | Index of the digest word, 0 = H0 |
| out_data | output | 32 | Digest word |

## Verification
The assertions check the following on every cycle:
- No padding or message word enters the schedule while compression is running.
- Compression always begins with its load cycle.
- The length count and IV pointer stay unchanged during idle input cycles and once the last word has been seen.
- The digest addresses form a gap-free 0-to-4 run.

Only the bench's scenarios can show that the digests are numerically correct. This covers:
- padding at every tail length across the block boundary (last word at indices 13, 14, 15 and beyond);
- bit-granular final words;
- custom chaining values;
- the 81-cycle stall;
- return to the default state between messages.

// File: rtl/sha1_pkg.sv
package sha1_pkg;
  localparam int WW        = 32;
  localparam int BLK_WORDS = 16;
  localparam int N_STEPS   = 80;
  localparam int N_ROUNDS  = 4;
  localparam int ROUND_LEN = N_STEPS / N_ROUNDS;
  localparam int H_WORDS   = 5;
  localparam int LEN_W     = 64;
  localparam int STEP_W    = $clog2(N_STEPS);
  localparam int IDX_W     = $clog2(BLK_WORDS);
  localparam int HA_W      = $clog2(H_WORDS);
  localparam int NB_W      = $clog2(WW);

  typedef logic [WW-1:0] word_t;
  typedef word_t [H_WORDS-1:0] chain_t;

  function automatic chain_t init_chain();
    chain_t c;
    c[0] = 32'h6745_2301;
    c[1] = 32'hEFCD_AB89;
    c[2] = 32'h98BA_DCFE;
    c[3] = 32'h1032_5476;
    c[4] = 32'hC3D2_E1F0;
    return c;
  endfunction

  function automatic word_t rotl(word_t x, int n);
    return (x << n) | (x >> (WW - n));
  endfunction

  function automatic word_t step_f(logic [STEP_W-1:0] t, word_t b, word_t c, word_t d);
    if (t < STEP_W'(ROUND_LEN))
      return (b & c) | (~b & d);
    else if (t >= STEP_W'(2*ROUND_LEN) && t < STEP_W'(3*ROUND_LEN))
      return (b & c) | (b & d) | (c & d);
    else
      return b ^ c ^ d;
  endfunction

  function automatic word_t step_k(logic [STEP_W-1:0] t);
    if (t < STEP_W'(ROUND_LEN))        return 32'h5A82_7999;
    else if (t < STEP_W'(2*ROUND_LEN)) return 32'h6ED9_EBA1;
    else if (t < STEP_W'(3*ROUND_LEN)) return 32'h8F1B_BCDC;
    else                               return 32'hCA62_C1D6;
  endfunction
endpackage

// File: rtl/sha1_sched.sv
module sha1_sched
  import sha1_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  word_t push_word,
  input  logic  advance,
  output word_t cur_word
);
  localparam int TAP3  = BLK_WORDS - 3;
  localparam int TAP8  = BLK_WORDS - 8;
  localparam int TAP14 = BLK_WORDS - 14;

  word_t win [BLK_WORDS];
  word_t expand;

  assign expand = rotl(win[TAP3] ^ win[TAP8] ^ win[TAP14] ^ win[0], 1);

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_win
    word_t nxt;
    if (i == BLK_WORDS - 1) begin : g_top
      assign nxt = push ? push_word : expand;
    end else begin : g_mid
      assign nxt = win[i+1];
    end
    always_ff @(posedge clk or posedge rst) begin
      if (rst) win[i] <= '0;
      else if (push || advance) win[i] <= nxt;
    end
  end

  assign cur_word = win[0];
endmodule

// File: rtl/sha1_compress.sv
module sha1_compress
  import sha1_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  word_t           cur_word,
  input  logic            iv_we,
  input  logic [HA_W-1:0] iv_idx,
  input  word_t           iv_word,
  input  logic            reinit,
  output logic            advance,
  output logic            busy,
  output logic            done,
  output chain_t          chain
);
  typedef enum logic [1:0] {C_IDLE, C_LOAD, C_RUN} cph_t;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  cph_t ph;
  logic [STEP_W-1:0] step;
  word_t a, b, c, d, e, t_new;

  assign t_new   = rotl(a, 5) + step_f(step, b, c, d) + e + step_k(step) + cur_word;
  assign advance = (ph == C_RUN);
  assign done    = (ph == C_RUN) && (step == LAST_STEP);
  assign busy    = (ph != C_IDLE);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ph <= C_IDLE; step <= '0;
      a <= '0; b <= '0; c <= '0; d <= '0; e <= '0;
      chain <= init_chain();
    end else begin
      case (ph)
        C_IDLE: begin
          if (start) ph <= C_LOAD;
          if (reinit) chain <= init_chain();
          else if (iv_we) chain[iv_idx] <= iv_word;
        end
        C_LOAD: begin
          a <= chain[0]; b <= chain[1]; c <= chain[2]; d <= chain[3]; e <= chain[4];
          step <= '0;
          ph <= C_RUN;
        end
        default: begin
          a <= t_new; b <= a; c <= rotl(b, 30); d <= c; e <= d;
          step <= step + 1'b1;
          if (done) begin
            ph <= C_IDLE;
            chain[0] <= chain[0] + t_new;
            chain[1] <= chain[1] + a;
            chain[2] <= chain[2] + rotl(b, 30);
            chain[3] <= chain[3] + c;
            chain[4] <= chain[4] + d;
          end
        end
      endcase
    end
  end

  // R6
  load_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == C_IDLE && start) |=> (ph == C_LOAD));
  // R6
  run_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);
  // R4
  iv_idle_chk: assert property (@(posedge clk) disable iff (rst)
    iv_we |-> (ph == C_IDLE));
endmodule

// File: rtl/sha1_feed.sv
module sha1_feed
  import sha1_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_iv,
  input  word_t           in_data,
  input  logic            in_last,
  input  logic [NB_W-1:0] in_nbits,
  output logic            in_ready,
  input  word_t           len_unused_n,
  output logic            push,
  output word_t           push_word,
  output logic            start,
  input  logic            core_done,
  output logic            iv_we,
  output logic [HA_W-1:0] iv_idx,
  output logic            out_go,
  input  logic            out_fin,
  output logic            reinit
);
  typedef enum logic [1:0] {F_MSG, F_PAD, F_HASH, F_OUT} fst_t;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_WORDS - 1);
  localparam logic [IDX_W-1:0] LEN_HI   = IDX_W'(BLK_WORDS - 2);
  localparam logic [IDX_W-1:0] ONE_MAX  = IDX_W'(BLK_WORDS - 3);
  localparam logic [NB_W:0]    FULL_NB  = (NB_W+1)'(WW);
  localparam word_t            TOP_BIT  = word_t'(1) << (WW - 1);

  fst_t st;
  logic [IDX_W-1:0] widx;
  logic [LEN_W-1:0] bitlen;
  logic one_done, fits, final_blk, tail;

  logic acc, msg_acc, iv_acc;
  logic [NB_W:0] nb_eff;
  word_t mask, one_bit, last_word, pad_word;

  assign in_ready = (st == F_MSG);
  assign acc      = in_valid && in_ready;
  assign msg_acc  = acc && !in_iv;
  assign iv_acc   = acc && in_iv;
  assign nb_eff   = (in_last && in_nbits != '0) ? {1'b0, in_nbits} : FULL_NB;
  assign mask     = ~({WW{1'b1}} >> nb_eff);
  assign one_bit  = (nb_eff == FULL_NB) ? '0 : (TOP_BIT >> nb_eff);
  assign last_word = (in_data & mask) | one_bit;

  always_comb begin
    if (!one_done)                  pad_word = TOP_BIT;
    else if (fits && widx == LEN_HI)   pad_word = bitlen[LEN_W-1:WW];
    else if (fits && widx == LAST_IDX) pad_word = bitlen[WW-1:0];
    else                            pad_word = '0;
  end

  assign push      = msg_acc || (st == F_PAD);
  assign push_word = msg_acc ? (in_last ? last_word : in_data) : pad_word;
  assign start     = push && (widx == LAST_IDX);
  assign iv_we     = iv_acc;
  assign out_go    = (st == F_HASH) && core_done && final_blk;
  assign reinit    = (st == F_OUT) && out_fin;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st <= F_MSG; widx <= '0; bitlen <= '0;
      one_done <= 1'b0; fits <= 1'b0; final_blk <= 1'b0; tail <= 1'b0; iv_idx <= '0;
    end else begin
      if (push) widx <= widx + 1'b1;
      if (iv_acc) iv_idx <= (iv_idx == HA_W'(H_WORDS - 1)) ? '0 : iv_idx + 1'b1;
      case (st)
        F_MSG: if (msg_acc) begin
          bitlen <= bitlen + LEN_W'(nb_eff);
          if (in_last) begin
            tail     <= 1'b1;
            one_done <= (nb_eff != FULL_NB);
            fits     <= (nb_eff != FULL_NB) && (widx <= ONE_MAX);
          end
          if (widx == LAST_IDX) begin
            st <= F_HASH; final_blk <= 1'b0;
          end else if (in_last) begin
            st <= F_PAD;
          end
        end
        F_PAD: begin
          if (!one_done) begin
            one_done <= 1'b1;
            fits     <= (widx <= ONE_MAX);
          end
          if (widx == LAST_IDX) begin
            st <= F_HASH;
            final_blk <= one_done && fits;
          end
        end
        F_HASH: if (core_done) begin
          if (final_blk) st <= F_OUT;
          else if (tail) begin
            st <= F_PAD;
            if (one_done) fits <= 1'b1;
          end else st <= F_MSG;
        end
        default: if (out_fin) begin
          st <= F_MSG; bitlen <= '0; tail <= 1'b0; one_done <= 1'b0;
          fits <= 1'b0; final_blk <= 1'b0; iv_idx <= '0;
        end
      endcase
    end
  end

  // R5
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (st == F_MSG && !in_valid) |=> ($stable(bitlen) && $stable(iv_idx) && $stable(widx)));
  // R3
  len_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (tail && st != F_OUT) |=> $stable(bitlen));

  logic unused_ok;
  assign unused_ok = ^len_unused_n;
endmodule

// File: rtl/sha1_digest_out.sv
module sha1_digest_out
  import sha1_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  chain_t          chain,
  output logic            fin,
  output logic            out_valid,
  output logic [HA_W-1:0] out_addr,
  output word_t           out_data
);
  localparam logic [HA_W-1:0] LAST_A = HA_W'(H_WORDS - 1);

  logic act;
  logic [HA_W-1:0] cnt;

  assign fin = act && (cnt == LAST_A);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act <= 1'b0; cnt <= '0;
      out_valid <= 1'b0; out_addr <= '0; out_data <= '0;
    end else begin
      out_valid <= act;
      if (act) begin
        out_addr <= cnt;
        out_data <= chain[cnt];
      end
      if (go) begin
        act <= 1'b1; cnt <= '0;
      end else if (fin) begin
        act <= 1'b0; cnt <= '0;
      end else if (act) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_addr != LAST_A) |=> (out_valid && out_addr == $past(out_addr) + 1'b1));
  // R7
  addr_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (out_addr == '0));
  // R7
  out_end_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_addr == LAST_A) |=> !out_valid);
endmodule

// File: rtl/sha1_stream_hasher.sv
module sha1_stream_hasher
  import sha1_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_iv,
  input  logic [31:0] in_data,
  input  logic        in_last,
  input  logic [4:0]  in_nbits,
  output logic        in_ready,
  output logic        out_valid,
  output logic [2:0]  out_addr,
  output logic [31:0] out_data
);
  logic push, start, core_done, core_busy, advance, iv_we, out_go, out_fin, reinit;
  word_t push_word, cur_word;
  logic [HA_W-1:0] iv_idx;
  chain_t chain;

  sha1_feed u_feed (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_iv(in_iv), .in_data(in_data),
    .in_last(in_last), .in_nbits(in_nbits), .in_ready(in_ready),
    .len_unused_n('0), .push(push), .push_word(push_word), .start(start),
    .core_done(core_done), .iv_we(iv_we), .iv_idx(iv_idx),
    .out_go(out_go), .out_fin(out_fin), .reinit(reinit)
  );

  sha1_sched u_sched (
    .clk(clk), .rst(rst), .push(push), .push_word(push_word),
    .advance(advance), .cur_word(cur_word)
  );

  sha1_compress u_core (
    .clk(clk), .rst(rst), .start(start), .cur_word(cur_word),
    .iv_we(iv_we), .iv_idx(iv_idx), .iv_word(in_data), .reinit(reinit),
    .advance(advance), .busy(core_busy), .done(core_done), .chain(chain)
  );

  sha1_digest_out u_out (
    .clk(clk), .rst(rst), .go(out_go), .chain(chain), .fin(out_fin),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
  );

  // R6
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    core_busy |-> (!in_ready && !push));
endmodule

// File: tb/sha1_stream_hasher_test.sv
module sha1_stream_hasher_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_iv = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [4:0] in_nbits = '0;
  logic in_ready, out_valid;
  logic [2:0] out_addr;
  logic [31:0] out_data;

  int checks = 0, errors = 0;
  int dcount = 0;
  int seq_err = 0;
  int exp_addr = 0;
  logic [31:0] dig [5];
  logic [31:0] msgbuf [40];
  localparam logic [159:0] STD_IV =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  always #5 clk = ~clk;

  sha1_stream_hasher uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_iv(in_iv), .in_data(in_data),
    .in_last(in_last), .in_nbits(in_nbits), .in_ready(in_ready),
    .out_valid(out_valid), .out_addr(out_addr), .out_data(out_data)
  );

  // digest monitor: also tracks the 0..4 consecutive address run
  logic prev_v = 1'b0;
  always @(negedge clk) begin
    if (out_valid) begin
      if (int'(out_addr) != exp_addr) seq_err++;
      dig[out_addr] = out_data;
      dcount++;
      exp_addr = (exp_addr == 4) ? 0 : exp_addr + 1;
    end else if (prev_v && exp_addr != 0) seq_err++;
    prev_v = out_valid;
  end

  function automatic logic [31:0] rl(logic [31:0] x, int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] model(int nw, int nb, logic [159:0] iv);
    logic [31:0] p [64];
    logic [31:0] w [80];
    logic [31:0] h [5];
    logic [31:0] a, b, c, d, e, f, k, t;
    int nbe, total, nblk;
    for (int i = 0; i < 64; i++) p[i] = '0;
    for (int i = 0; i < nw; i++) p[i] = msgbuf[i];
    nbe = (nb == 0) ? 32 : nb;
    p[nw-1] = p[nw-1] & 32'((64'hFFFF_FFFF << (32 - nbe)));
    total = (nw - 1) * 32 + nbe;
    p[total/32][31 - (total % 32)] = 1'b1;
    nblk = (total + 1 + 64 + 511) / 512;
    p[nblk*16-1] = 32'(total);
    for (int i = 0; i < 5; i++) h[i] = iv[159 - 32*i -: 32];
    for (int bk = 0; bk < nblk; bk++) begin
      for (int s = 0; s < 16; s++) w[s] = p[bk*16 + s];
      for (int s = 16; s < 80; s++) w[s] = rl(w[s-3] ^ w[s-8] ^ w[s-14] ^ w[s-16], 1);
      a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
      for (int s = 0; s < 80; s++) begin
        if (s < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
        else if (s < 40) begin f = b ^ c ^ d;                    k = 32'h6ED9EBA1; end
        else if (s < 60) begin f = (b & c) | (b & d) | (c & d);  k = 32'h8F1BBCDC; end
        else             begin f = b ^ c ^ d;                    k = 32'hCA62C1D6; end
        t = rl(a, 5) + f + e + k + w[s];
        e = d; d = c; c = rl(b, 30); b = a; a = t;
      end
      h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e;
    end
    return {h[0], h[1], h[2], h[3], h[4]};
  endfunction

  task automatic chk(bit ok, string what, logic [159:0] got, logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  // drive one word; caller is at a negedge
  task automatic send_word(logic [31:0] dv, bit iv, bit last, logic [4:0] nb);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_iv = iv; in_data = dv; in_last = last; in_nbits = nb;
    @(negedge clk);
    // junk while in_valid is low (R5)
    in_valid = 1'b0; in_iv = 1'b1; in_last = 1'b1; in_data = ~dv; in_nbits = 5'h13;
  endtask

  int stall_len = -1;

  task automatic run_msg(int nw, int nb, bit use_iv, logic [159:0] iv, string tag);
    int tgt;
    logic [159:0] exp, got;
    seq_err = 0;
    tgt = dcount + 5;
    if (use_iv)
      for (int i = 0; i < 5; i++) send_word(iv[159 - 32*i -: 32], 1'b1, 1'b0, 5'h0);
    for (int i = 0; i < nw; i++) begin
      send_word(msgbuf[i], 1'b0, i == nw - 1, (i == nw - 1) ? 5'(nb) : 5'((i * 7) & 31));
      if (i == 15 && nw > 16) begin
        stall_len = 0;
        while (!in_ready) begin stall_len++; @(negedge clk); end
      end
    end
    while (dcount < tgt) @(negedge clk);
    got = {dig[0], dig[1], dig[2], dig[3], dig[4]};
    exp = model(nw, nb, use_iv ? iv : STD_IV);
    chk(got == exp, $sformatf("%s len=%0d nbits=%0d", tag, nw, nb), got, exp);
  endtask

  function automatic void fill(int seed);
    for (int i = 0; i < 40; i++)
      msgbuf[i] = (32'h9E3779B9 * 32'(i + 1 + seed)) ^ 32'(seed << 11);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(in_ready === 1'b1, "R1 in_ready after reset", 160'(in_ready), 160'(1));
    chk(out_valid === 1'b0, "R1 out_valid after reset", 160'(out_valid), 160'(0));

    // R2 R3 known answer: "abc" as 24 bits
    msgbuf[0] = 32'h61626300;
    run_msg(1, 24, 1'b0, STD_IV, "R2 R3 abc");
    chk(model(1, 24, STD_IV) == 160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D,
        "R2 bench model abc", model(1, 24, STD_IV),
        160'hA9993E36_4706816A_BA3E2571_7850C26C_9CD0D89D);
    chk(seq_err == 0, "R7 address run", 160'(seq_err), 160'(0));

    // R2 R3 length sweep across block boundaries
    for (int n = 1; n <= 34; n++) begin
      fill(n);
      run_msg(n, 0, 1'b0, STD_IV, "R2 R3 sweep");
      chk(seq_err == 0, "R7 address run", 160'(seq_err), 160'(0));
    end

    // R3 bit-granular tails at the last-fit and no-fit positions
    for (int nb = 0; nb < 32; nb++) begin
      fill(100 + nb);
      run_msg(14, nb, 1'b0, STD_IV, "R3 tail idx13");
      run_msg(16, nb, 1'b0, STD_IV, "R3 tail idx15");
    end

    // R6 stall length after the 16th word of a non-final block
    fill(7);
    run_msg(20, 5, 1'b0, STD_IV, "R6 R2 stall msg");
    chk(stall_len == 81, "R6 in_ready low cycles", 160'(stall_len), 160'(81));

    // R4 custom chaining value, then R8 back to defaults
    fill(55);
    run_msg(3, 9, 1'b1, 160'h01234567_89ABCDEF_FEDCBA98_76543210_0F1E2D3C, "R4 iv");
    run_msg(3, 9, 1'b0, STD_IV, "R8 default after iv");
    fill(56);
    run_msg(18, 0, 1'b1, 160'hDEADBEEF_00000001_80000000_55AA55AA_CAFEF00D, "R4 iv 2blk");
    // R8 back-to-back identical messages
    run_msg(18, 0, 1'b0, STD_IV, "R8 repeat a");
    run_msg(18, 0, 1'b0, STD_IV, "R8 repeat b");

    // R5 long idle with junk on every input while in_valid is low
    in_valid = 1'b0; in_iv = 1'b1; in_last = 1'b1; in_data = 32'hFFFF_FFFF; in_nbits = 5'h1F;
    repeat (40) @(negedge clk);
    chk(out_valid === 1'b0, "R5 no output from idle junk", 160'(out_valid), 160'(0));
    fill(9);
    run_msg(2, 17, 1'b0, STD_IV, "R5 after idle junk");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule